// File: doc/BRIEF.md
# Two-Digit Decimal Seconds Counter (00 to 59)

This block is a two-digit decimal counter. It steps through 00, 01, up to 59 and then wraps to 00. It is made of two counting stages in a chain. The low stage holds the ones digit and counts through ten values. The high stage holds the tens digit and counts through six values. The high stage moves only when the low stage passes its carry on. The design is not one binary counter; it is two binary-coded-decimal stages with different moduli.

The clock is expected to be a slow tick already, or to be qualified upstream. A level from a slide switch gates counting, and a push button gives a synchronous clear. The counter drives both digits out as 4-bit BCD. It also drives an indicator lamp that follows the switch, and a flag that marks the last count before the wrap.

Each stage picks one of three operations every cycle, named in the shared package:
- `OP_CLEAR` forces the digit to zero. It wins over everything else.
- `OP_STEP` advances the digit, or returns it to zero from its last value.
- `OP_HOLD` keeps the digit as it is.

Top module: `sec60_counter`

## Requirements
- R1: When `clr` is high at a rising clock edge, both digits read 0 after that edge, whatever `cnt_en` is.
- R2: With `clr` low and `cnt_en` high, `ones_bcd` rises by one at each edge. From 9 it goes to 0.
- R3: `tens_bcd` changes only at an edge where `ones_bcd` was 9, `cnt_en` was high and `clr` was low. At that edge it rises by one.
- R4: At count 59 with `cnt_en` high and `clr` low, the next edge gives 00. Over 60 enabled edges the count passes through every value from 00 to 59 exactly once.
- R5: With `cnt_en` low and `clr` low, both digits keep their values at every edge.
- R6: `en_led` equals `cnt_en` at all times, with no clock delay.
- R7: `at_max` is high exactly when the count is 59 and `cnt_en` is high. It is combinational, so it is valid in the same cycle.
- R8: `ones_bcd` never exceeds 9 and `tens_bcd` never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting tick clock |
| clr | input | 1 | Synchronous clear from the push button, active high |
| cnt_en | input | 1 | Count enable level from the slide switch |
| ones_bcd | output | 4 | Ones digit in BCD (0 to 9) |
| tens_bcd | output | 4 | Tens digit in BCD (0 to 5) |
| en_led | output | 1 | Lamp that shows the enable level |
| at_max | output | 1 | High when the count is 59 and counting is enabled |

## Verification
The digit outputs come straight from the stage registers. A change in `clr` or `cnt_en` therefore shows up in `ones_bcd` and `tens_bcd` one rising edge later. `en_led` and `at_max` are combinational and are valid in the same cycle as the inputs that drive them.

The bench changes its inputs on the falling edge and waits a short delay before it checks the two combinational outputs. It then waits for the rising edge, updates its own count model, and compares both digits on the following falling edge. Every check is therefore made half a cycle away from the edge that moved the value.

// File: rtl/sec60_pkg.sv
package sec60_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_CLEAR = 2'd2
    } stage_op_e;
endpackage

// File: rtl/bcd_stage.sv
module bcd_stage
    import sec60_pkg::*;
#(
    parameter int MODULUS = 10,
    parameter int W       = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         step_en,
    output logic [W-1:0] value,
    output logic         carry
);
    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    stage_op_e    op;
    logic [W-1:0] value_nxt;

    // operation select: clear beats step, step beats hold
    always_comb begin
        if (clr)
            op = OP_CLEAR;
        else if (step_en)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end

    // next digit for each operation
    always_comb begin
        unique case (op)
            OP_CLEAR: value_nxt = '0;
            OP_STEP:  value_nxt = (value == LAST) ? '0 : value + 1'b1;
            OP_HOLD:  value_nxt = value;
            default:  value_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        value <= value_nxt;
    end

    // carry leaves only on a real step out of the last value
    always_comb begin
        carry = step_en && (value == LAST);
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk) clr |=> value == '0);

    // R8
    range_chk: assert property (@(posedge clk) disable iff (clr) value <= LAST);

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (clr)
        (step_en && value != LAST) |=> value == $past(value) + 1'b1);

    // R4
    step_wrap_chk: assert property (@(posedge clk) disable iff (clr)
        (step_en && value == LAST) |=> value == '0);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (clr)
        !step_en |=> $stable(value));
endmodule

// File: rtl/sec60_counter.sv
module sec60_counter #(
    parameter int DIGIT_W  = 4,
    parameter int ONES_MOD = 10,
    parameter int TENS_MOD = 6
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               cnt_en,
    output logic [DIGIT_W-1:0] ones_bcd,
    output logic [DIGIT_W-1:0] tens_bcd,
    output logic               en_led,
    output logic               at_max
);
    localparam logic [DIGIT_W-1:0] ONES_LAST = DIGIT_W'(ONES_MOD - 1);
    localparam logic [DIGIT_W-1:0] TENS_LAST = DIGIT_W'(TENS_MOD - 1);

    logic ones_carry;
    logic tens_carry;

    bcd_stage #(.MODULUS(ONES_MOD), .W(DIGIT_W)) u_ones (
        .clk     (clk),
        .clr     (clr),
        .step_en (cnt_en),
        .value   (ones_bcd),
        .carry   (ones_carry)
    );

    bcd_stage #(.MODULUS(TENS_MOD), .W(DIGIT_W)) u_tens (
        .clk     (clk),
        .clr     (clr),
        .step_en (ones_carry),
        .value   (tens_bcd),
        .carry   (tens_carry)
    );

    always_comb begin
        en_led = cnt_en;
        at_max = tens_carry;
    end

    // R3
    tens_gate_chk: assert property (@(posedge clk) disable iff (clr)
        (!$past(clr) && tens_bcd != $past(tens_bcd)) |->
            ($past(ones_bcd) == ONES_LAST && $past(cnt_en)));

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (clr)
        at_max |=> (ones_bcd == '0 && tens_bcd == '0));

    // R7
    max_flag_chk: assert property (@(posedge clk) disable iff (clr)
        at_max |-> (tens_bcd == TENS_LAST && ones_bcd == ONES_LAST && cnt_en));

    // R6
    led_follow_chk: assert property (@(posedge clk) en_led == cnt_en);
endmodule

// File: tb/sim_sec60_counter.sv
module sim_sec60_counter;
    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       cnt_en = 1'b0;
    logic [3:0] ones_bcd, tens_bcd;
    logic       en_led, at_max;

    int n_cmp  = 0;
    int n_miss = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sec60_counter u0 (
        .clk(clk), .clr(clr), .cnt_en(cnt_en),
        .ones_bcd(ones_bcd), .tens_bcd(tens_bcd),
        .en_led(en_led), .at_max(at_max)
    );

    task automatic cmp(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_miss++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check comb outputs, step model, check digits
    task automatic tick(input bit en, input bit c, input string req);
        cnt_en = en;
        clr    = c;
        #2;
        cmp("R6 en_led", int'(en_led), int'(en));
        cmp("R7 at_max", int'(at_max), int'(model == 59 && en));
        @(posedge clk);
        if (c)       model = 0;
        else if (en) model = (model + 1) % 60;
        @(negedge clk);
        cmp({req, " ones"}, int'(ones_bcd), model % 10);
        cmp({req, " tens"}, int'(tens_bcd), model / 10);
        cmp("R8 range", int'(ones_bcd <= 9 && tens_bcd <= 5), 1);
    endtask

    task automatic t_reset();
        tick(1'b0, 1'b1, "R1 reset");
        tick(1'b1, 1'b1, "R1 clear over enable");
    endtask

    task automatic t_full_run();
        for (int i = 0; i < 75; i++) tick(1'b1, 1'b0, "R2 R3 R4 count");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, "R5 hold");
        while (model % 10 != 9) tick(1'b1, 1'b0, "R2 approach");
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, "R3 R5 hold at 9");
        tick(1'b1, 1'b0, "R3 tens step");
    endtask

    task automatic t_terminal();
        while (model != 59) tick(1'b1, 1'b0, "R2 approach");
        tick(1'b0, 1'b0, "R7 at 59 disabled");
        tick(1'b1, 1'b0, "R4 wrap");
    endtask

    task automatic t_clear_mid();
        for (int i = 0; i < 27; i++) tick(1'b1, 1'b0, "R2 count");
        tick(1'b1, 1'b1, "R1 mid clear");
        tick(1'b1, 1'b0, "R2 after clear");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_full_run();
        t_hold();
        t_terminal();
        t_clear_mid();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_miss++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end
endmodule